// File: doc/BRIEF.md
# Module Hit Concentrator

This block gathers matched hit words from a row of column assemblers on one side of a detector module and forwards them, one at a time, over a narrow byte-wide bus toward the off-module link. Each source raises a one-cycle strobe with a 10-bit pattern word. The concentrator stores the word until the source is served. It then builds a 16-bit record from the source index, the word and an end-of-burst flag, and sends that record as two consecutive bytes with a busy line held high.

The block runs on the byte clock, which is twice the crossing rate, so one record fits into one crossing period. Sources are served in rotating order, so a hot source cannot starve its neighbours. Each source receives a one-cycle grant when its stored word is taken. If a source strobes again while its earlier word is still waiting, the new word is discarded and a per-source saturating overflow counter records the loss.

Top module: `hit_concentrator`

## Requirements
- R1: After reset, out_busy is 0, out_byte is 0, src_grant is all zero, every overflow counter reads 0 and no source is pending.
- R2: A stored word is sent as a 16-bit record {source index[4:0], word[9:0], last}, high byte first. The first byte is {index, word[9:7]} and the second is {word[6:0], last}. The first byte appears two cycles after the strobe edge when the bus is idle.
- R3: out_busy is high for exactly the two byte cycles of each record and is low when nothing is being sent. While busy is low, out_byte is 0.
- R4: src_grant is a one-cycle pulse on the served source's bit only, in the same cycle as that record's first byte. At most one grant bit is high at any time.
- R5: Sources are served round robin. After source k is served, the next record comes from the first pending source above k, wrapping from the highest index to 0. After reset, the search starts at source 0.
- R6: The last bit is 1 when no other source is pending at the moment a record is taken, and 0 otherwise.
- R7: A pending word is held unchanged until it is served. A strobe on a source that is already pending has no effect on the word that is sent.
- R8: A strobe on a pending source that is not taken in that same cycle increments that source's overflow counter. The counter saturates at its maximum and is cleared only by reset.
- R9: A strobe on a source in the same cycle its word is taken stores the new word as pending and does not count as an overflow.
- R10: When further sources are pending, the next record's first byte follows the previous record's second byte with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, twice the crossing rate |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_stb | input | N_SRC | One-cycle new-hit strobe per source |
| hit_data | input | N_SRC*DATA_W | Hit words, source i at bits [i*DATA_W +: DATA_W] |
| src_grant | output | N_SRC | One-cycle pulse when a source's word is taken |
| out_byte | output | (clog2(N_SRC)+DATA_W+1)/2 | Output byte, record high byte first |
| out_busy | output | 1 | High during each byte of a record |
| ovf_count | output | N_SRC*CNT_W | Saturating overflow counters, source i at bits [i*CNT_W +: CNT_W] |

## Verification
The bench uses the default 32 sources and 10-bit words, so the index field fills five bits and source 31 tests the wrap of the rotating search. The overflow counters are built with a width of 3 bits. With that width, a single source held waiting behind sixteen others can receive more strobes than the counter can hold, which brings the saturation limit within reach. Directed runs cover a lone hit, simultaneous hits, a pointer left mid-range by an earlier grant, and strobes that collide with a pending or just-granted word.

// File: rtl/hit_concentrator.sv
module hit_concentrator #(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 10,
  parameter int CNT_W  = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [N_SRC-1:0]                       hit_stb,
  input  logic [N_SRC*DATA_W-1:0]                hit_data,
  output logic [N_SRC-1:0]                       src_grant,
  output logic [($clog2(N_SRC)+DATA_W+1)/2-1:0]  out_byte,
  output logic                                   out_busy,
  output logic [N_SRC*CNT_W-1:0]                 ovf_count
);
  localparam int AW     = $clog2(N_SRC);
  localparam int REC_W  = AW + DATA_W + 1;
  localparam int BYTE_W = REC_W / 2;

  logic [N_SRC-1:0]  pend;
  logic [DATA_W-1:0] store [N_SRC];
  logic [AW-1:0]     ptr, sel;
  logic              found, others, accept;
  logic              busy, phase;
  logic [REC_W-1:0]  rec;
  logic [N_SRC-1:0]  grant_q;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int k = 1; k <= N_SRC; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= N_SRC) j = j - N_SRC;
      if (!found && pend[j]) begin
        found = 1'b1;
        sel   = AW'(j);
      end
    end
  end

  assign others = |(pend & ~(N_SRC'(1) << sel));
  assign accept = found && (!busy || phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      phase   <= 1'b0;
      rec     <= '0;
      grant_q <= '0;
      ptr     <= AW'(N_SRC - 1);
    end else begin
      grant_q <= accept ? (N_SRC'(1) << sel) : '0;
      if (accept) begin
        busy  <= 1'b1;
        phase <= 1'b0;
        rec   <= {sel, store[sel], ~others};
        ptr   <= sel;
      end else if (busy && !phase) begin
        phase <= 1'b1;
      end else begin
        busy  <= 1'b0;
        phase <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic [CNT_W-1:0] cnt;
    logic             taken;
    assign taken = accept && (sel == AW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[i]  <= 1'b0;
        store[i] <= '0;
        cnt      <= '0;
      end else if (hit_stb[i]) begin
        if (pend[i] && !taken) begin
          if (cnt != {CNT_W{1'b1}}) cnt <= cnt + 1'b1;
        end else begin
          pend[i]  <= 1'b1;
          store[i] <= hit_data[i*DATA_W +: DATA_W];
        end
      end else if (taken) begin
        pend[i] <= 1'b0;
      end
    end

    assign ovf_count[i*CNT_W +: CNT_W] = cnt;
  end

  assign src_grant = grant_q;
  assign out_busy  = busy;
  assign out_byte  = !busy ? '0 : (phase ? rec[BYTE_W-1:0] : rec[REC_W-1:BYTE_W]);

endmodule

// File: rtl/hit_concentrator_props.sv
module hit_concentrator_props #(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 10,
  parameter int CNT_W  = 8
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic [N_SRC-1:0]                       src_grant,
  input logic [($clog2(N_SRC)+DATA_W+1)/2-1:0]  out_byte,
  input logic                                   out_busy,
  input logic [N_SRC*CNT_W-1:0]                 ovf_count
);
  // R4
  grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_grant));

  // R4
  grant_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_grant) |-> out_busy);

  // R4
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_grant) |=> (src_grant == '0));

  // R3
  busy_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_busy) |=> out_busy);

  // R3
  busy_start_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_busy) |-> ($countones(src_grant) == 1));

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_busy |-> (out_byte == '0));

  for (genvar i = 0; i < N_SRC; i++) begin : g_cnt
    // R8
    ovf_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_count[i*CNT_W +: CNT_W] >= $past(ovf_count[i*CNT_W +: CNT_W]));
  end
endmodule

bind hit_concentrator hit_concentrator_props #(
  .N_SRC(N_SRC), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_props (
  .clk(clk), .rst_n(rst_n), .src_grant(src_grant),
  .out_byte(out_byte), .out_busy(out_busy), .ovf_count(ovf_count)
);

// File: tb/sim_hit_concentrator.sv
module sim_hit_concentrator;
  localparam int N  = 32;
  localparam int DW = 10;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  hit_stb = '0;
  logic [N*DW-1:0] hit_data = '0;
  logic [N-1:0]  src_grant;
  logic [7:0]    out_byte;
  logic          out_busy;
  logic [N*CW-1:0] ovf_count;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  hit_concentrator #(.N_SRC(N), .DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .hit_stb(hit_stb), .hit_data(hit_data),
    .src_grant(src_grant), .out_byte(out_byte), .out_busy(out_busy),
    .ovf_count(ovf_count)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; hit_stb = '0; hit_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic put(input int s, input logic [DW-1:0] d);
    hit_stb[s] = 1'b1;
    hit_data[s*DW +: DW] = d;
  endtask

  function automatic logic [CW-1:0] cnt_of(input int s);
    return ovf_count[s*CW +: CW];
  endfunction

  task automatic expect_rec(input int s, input logic [DW-1:0] d, input bit last,
                            input string tag, output int waited);
    logic [4:0] a;
    a = s[4:0];
    waited = 0;
    @(posedge clk); #2;
    while (src_grant == '0 && waited < 40) begin
      waited++;
      @(posedge clk); #2;
    end
    chk(out_busy === 1'b1, {tag, " busy on high byte (R3)"}, out_busy, 1);
    chk(src_grant === (N'(1) << s), {tag, " grant pulse (R4)"}, src_grant, N'(1) << s);
    chk(out_byte === {a, d[9:7]}, {tag, " high byte (R2)"}, out_byte, {a, d[9:7]});
    @(posedge clk); #2;
    chk(out_busy === 1'b1, {tag, " busy on low byte (R3)"}, out_busy, 1);
    chk(src_grant === '0, {tag, " grant cleared (R4)"}, src_grant, 0);
    chk(out_byte === {d[6:0], last}, {tag, " low byte with last flag (R2 R6)"},
        out_byte, {d[6:0], last});
  endtask

  task automatic t_reset();
    do_reset();
    @(posedge clk); #2;
    chk(out_busy === 1'b0, "R1 busy after reset", out_busy, 0);
    chk(out_byte === 8'h00, "R1 byte after reset", out_byte, 0);
    chk(src_grant === '0, "R1 grant after reset", src_grant, 0);
    chk(ovf_count === '0, "R1 counters after reset", ovf_count, 0);
    repeat (3) @(posedge clk);
    #2;
    chk(out_busy === 1'b0, "R1 no pending source sends", out_busy, 0);
  endtask

  task automatic t_single();
    int w;
    do_reset();
    @(negedge clk); put(12, 10'h2C5);
    @(negedge clk); hit_stb = '0;
    expect_rec(12, 10'h2C5, 1'b1, "R2 single hit", w);
    chk(w == 0, "R2 first byte two cycles after strobe", w, 0);
    @(posedge clk); #2;
    chk(out_busy === 1'b0, "R3 busy drops after record", out_busy, 0);
    chk(out_byte === 8'h00, "R3 byte zero when idle", out_byte, 0);
  endtask

  task automatic t_multi();
    int w;
    do_reset();
    @(negedge clk); put(20, 10'h155); put(3, 10'h0F0); put(7, 10'h3FF);
    @(negedge clk); hit_stb = '0;
    expect_rec(3, 10'h0F0, 1'b0, "R5 first of three", w);
    expect_rec(7, 10'h3FF, 1'b0, "R5 second of three", w);
    chk(w == 0, "R10 no gap before second", w, 0);
    expect_rec(20, 10'h155, 1'b1, "R6 last of three", w);
    chk(w == 0, "R10 no gap before third", w, 0);
  endtask

  task automatic t_rr();
    int w;
    do_reset();
    @(negedge clk); put(5, 10'h1A1);
    @(negedge clk); hit_stb = '0;
    expect_rec(5, 10'h1A1, 1'b1, "R5 pointer setup", w);
    @(negedge clk); put(2, 10'h222); put(9, 10'h099);
    @(negedge clk); hit_stb = '0;
    expect_rec(9, 10'h099, 1'b0, "R5 above pointer first", w);
    expect_rec(2, 10'h222, 1'b1, "R5 wrap to lower index", w);
  endtask

  task automatic t_ovf();
    int w;
    do_reset();
    @(negedge clk); put(1, 10'h111); put(2, 10'h2B2);
    fork
      begin
        @(negedge clk); hit_stb = '0; put(1, 10'h3D1); put(2, 10'h0CC);
        @(negedge clk); hit_stb = '0;
      end
      begin
        expect_rec(1, 10'h111, 1'b0, "R5 ovf case first", w);
        expect_rec(2, 10'h2B2, 1'b0, "R7 pending word kept", w);
        expect_rec(1, 10'h3D1, 1'b1, "R9 word stored at grant", w);
      end
    join
    chk(cnt_of(2) == 3'd1, "R8 overflow counted", cnt_of(2), 1);
    chk(cnt_of(1) == 3'd0, "R9 no overflow at grant", cnt_of(1), 0);
  endtask

  task automatic t_sat();
    int w;
    do_reset();
    @(negedge clk);
    for (int k = 0; k < 16; k++) put(k, 10'(10'h240 + k * 7));
    put(31, 10'h2E7);
    fork
      begin
        for (int j = 1; j <= 10; j++) begin
          @(negedge clk); hit_stb = '0; put(31, 10'(j));
        end
        @(negedge clk); hit_stb = '0;
      end
      begin
        for (int k = 0; k < 16; k++)
          expect_rec(k, 10'(10'h240 + k * 7), 1'b0, "R5 drain in order", w);
        expect_rec(31, 10'h2E7, 1'b1, "R7 held word on top index", w);
      end
    join
    chk(cnt_of(31) == 3'd7, "R8 counter saturates", cnt_of(31), 7);
    chk(cnt_of(0) == 3'd0, "R8 other counter untouched", cnt_of(0), 0);
    @(posedge clk); #2;
    chk(cnt_of(31) == 3'd7, "R8 counter kept after grant", cnt_of(31), 7);
    chk(out_busy === 1'b0, "R3 idle after drain", out_busy, 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_multi();
    t_rr();
    t_ovf();
    t_sat();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule